// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus. Through it a host reads and writes 16-bit control and status registers that sit behind a simple register port. The host owns the serial clock and alone creates start and stop conditions. The block samples the serial clock line and the data line with a much faster local clock. It recognises start, repeated start and stop. It pulls the data line low, open-drain, to acknowledge and to send read data.

A write is five bytes long: the device byte with the direction bit clear, the register address high byte, the register address low byte, the data high byte and the data low byte. A read first writes the two address bytes. The host then issues a repeated start and a device byte with the direction bit set, and the block returns the word, high byte first. Transfers that carry only an 8-bit address or only 8-bit data never reach the register port. The local clock must run at least 22 times faster than the serial clock.

Top module: `twr_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and neither `reg_we` nor `reg_re` is asserted.
- R2: A start seen while the serial clock is high restarts device-byte reception, even without a prior stop. This holds in any state, including part way through the address bytes.
- R3: The device byte carries a 7-bit address in bits 7..1, compared against parameter `DEV_ADDR`, and a direction bit in bit 0 (0 = write, 1 = read). On a match the block pulls the line low in the acknowledge slot. On a mismatch it does not acknowledge, and it leaves the line released for every following byte until the next start.
- R4: In a write, each of the five bytes is acknowledged. A single-cycle `reg_we` is then issued, with `reg_addr` = {address high, address low} and `reg_wdata` = {data high, data low}. Any further byte before the next start is not acknowledged.
- R5: If a stop ends a write after only one address byte, or after only one data byte, `reg_we` is never asserted.
- R6: Once a read device byte is acknowledged, a single `reg_re` is issued with `reg_addr` holding the last written address. `reg_rdata` is captured when the acknowledge slot ends. The block then shifts out bits 15..8, then bits 7..0, each MSB first.
- R7: If the host does not acknowledge the read high byte, the block releases the line for the rest of the transaction, so the next byte reads as 8'hFF.
- R8: `sda_oe` changes only while the serial clock is low.
- R9: `reg_we` and `reg_re` are each single-cycle pulses and are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least 22x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| reg_addr | output | 16 | Register address assembled from the bus |
| reg_wdata | output | 16 | Write data assembled from the bus |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read request |
| reg_rdata | input | 16 | Read data, valid from the cycle after `reg_re` |

## Verification
A wrong bit count or a wrong framing state shows up within one byte time. Either an acknowledge is missing where one is due, or one appears where none is due. A broken address or direction decode shows up the same way, at the ninth serial clock of the device byte. If the shift register or the byte steering is wrong, `reg_addr` and `reg_wdata` carry the wrong values in the cycle `reg_we` pulses. Read bytes then come back with the halves swapped or shifted. Faults in the strobe timing are seen at once: an extra or a missing pulse, or a write strobe after a truncated transfer.

// File: rtl/twr_pkg.sv
package twr_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [3:0] {
      ST_IDLE, ST_DEV, ST_ADR_HI, ST_ADR_LO, ST_WR_HI, ST_WR_LO,
      ST_RD_HI, ST_RD_LO, ST_SKIP
   } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q_prev <= '1;
      else        q_prev <= chain[STAGES-1];

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twr_cond.sv
module twr_cond (
   input  logic scl_now,
   input  logic scl_old,
   input  logic sda_now,
   input  logic sda_old,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   always_comb begin
      scl_rise = scl_now & ~scl_old;
      scl_fall = ~scl_now & scl_old;
      start_c  = scl_now & scl_old & sda_old & ~sda_now;
      stop_c   = scl_now & scl_old & ~sda_old & sda_now;
   end
endmodule

// File: rtl/twr_engine.sv
module twr_engine
   import twr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h48,
   parameter int         AW       = 16,
   parameter int         DW       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_c,
   input  logic          stop_c,
   input  logic          sda_s,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_we,
   output logic          reg_re,
   input  logic [DW-1:0] reg_rdata
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   twr_state_e         state;
   logic [CNT_W-1:0]   cnt;
   logic               in_ack, rd_dir, mack;
   logic [BYTE_W-1:0]  sh, tx, rd_lo;
   logic               accept, tx_state, active;

   always_comb begin
      tx_state = (state == ST_RD_HI) || (state == ST_RD_LO);
      active   = (state != ST_IDLE) && (state != ST_SKIP);
      case (state)
         ST_DEV:                                     accept = (sh[7:1] == DEV_ADDR);
         ST_ADR_HI, ST_ADR_LO, ST_WR_HI, ST_WR_LO:   accept = 1'b1;
         default:                                    accept = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; in_ack <= 1'b0; rd_dir <= 1'b0; mack <= 1'b0;
         sh <= '0; tx <= '0; rd_lo <= '0; sda_oe <= 1'b0;
         reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0; reg_re <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         if (start_c) begin
            state <= ST_DEV; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
         end else if (stop_c) begin
            state <= ST_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
         end else if (active && scl_rise) begin
            if (in_ack) mack <= ~sda_s;
            else if (cnt < CNT_W'(BYTE_W)) begin
               sh  <= {sh[BYTE_W-2:0], sda_s};
               cnt <= cnt + 1'b1;
            end
         end else if (active && scl_fall) begin
            if (!in_ack && cnt == CNT_W'(BYTE_W)) begin
               in_ack <= 1'b1;
               if (tx_state) sda_oe <= 1'b0;
               else begin
                  sda_oe <= accept;
                  case (state)
                     ST_DEV:    begin rd_dir <= sh[0]; reg_re <= accept & sh[0]; end
                     ST_ADR_HI: reg_addr[AW-1 -: BYTE_W]  <= sh;
                     ST_ADR_LO: reg_addr[BYTE_W-1:0]      <= sh;
                     ST_WR_HI:  reg_wdata[DW-1 -: BYTE_W] <= sh;
                     ST_WR_LO:  reg_wdata[BYTE_W-1:0]     <= sh;
                     default:   ;
                  endcase
                  if (!accept) state <= ST_SKIP;
               end
            end else if (in_ack) begin
               in_ack <= 1'b0;
               cnt    <= '0;
               sda_oe <= 1'b0;
               case (state)
                  ST_DEV: if (rd_dir) begin
                     state  <= ST_RD_HI;
                     tx     <= reg_rdata[DW-1 -: BYTE_W];
                     rd_lo  <= reg_rdata[BYTE_W-1:0];
                     sda_oe <= ~reg_rdata[DW-1];
                  end else state <= ST_ADR_HI;
                  ST_ADR_HI: state <= ST_ADR_LO;
                  ST_ADR_LO: state <= ST_WR_HI;
                  ST_WR_HI:  state <= ST_WR_LO;
                  ST_WR_LO:  begin reg_we <= 1'b1; state <= ST_SKIP; end
                  ST_RD_HI: if (mack) begin
                     state  <= ST_RD_LO;
                     tx     <= rd_lo;
                     sda_oe <= ~rd_lo[BYTE_W-1];
                  end else state <= ST_SKIP;
                  default:   state <= ST_SKIP;
               endcase
            end else if (tx_state && cnt != '0) begin
               sda_oe <= ~tx[3'(BYTE_W - 1) - cnt[2:0]];
            end
         end
      end
   end
endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h48,
   parameter int         AW          = 16,
   parameter int         DW          = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_we,
   output logic          reg_re,
   input  logic [DW-1:0] reg_rdata
);
   if (AW != 2 * twr_pkg::BYTE_W) begin : g_bad_aw
      $error("twr_slave: AW must be two bytes");
   end
   if (DW != 2 * twr_pkg::BYTE_W) begin : g_bad_dw
      $error("twr_slave: DW must be two bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twr_slave: SYNC_STAGES must be at least 2");
   end

   logic [1:0] ln_now, ln_old;
   logic       scl_rise, scl_fall, start_c, stop_c;

   twr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(ln_now), .q_prev(ln_old)
   );

   twr_cond u_cond (
      .scl_now(ln_now[1]), .scl_old(ln_old[1]),
      .sda_now(ln_now[0]), .sda_old(ln_old[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
   );

   twr_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
      .sda_s(ln_now[0]), .sda_oe(sda_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
   );
endmodule

// File: rtl/twr_chk.sv
module twr_chk #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_i,
   input logic          sda_oe,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          reg_we,
   input logic          reg_re,
   input logic [DW-1:0] reg_rdata
);
   a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   a_r9_re_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);
   a_r9_no_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);
   a_r4_we_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !sda_oe);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!sda_oe && !reg_we && !reg_re));
endmodule

bind twr_slave twr_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/twr_slave_tb.sv
module twr_slave_tb;
   localparam logic [6:0] DEV = 7'h48;
   localparam int HALF = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic sda_oe, reg_we, reg_re;
   logic [15:0] reg_addr, reg_wdata, rdata_m;
   logic sda_bus;
   int tests = 0, fails = 0, we_cnt = 0, re_cnt = 0, r8_viol = 0, r9_viol = 0;
   logic [15:0] we_addr, we_data;
   logic prev_oe = 1'b0, prev_we = 1'b0, done = 1'b0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   twr_slave #(.DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_rdata(rdata_m)
   );

   function automatic logic [15:0] model(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   always @(posedge clk) begin
      if (reg_re) rdata_m <= model(reg_addr);
      if (reg_re) re_cnt++;
      if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
   end
   always @(negedge clk) begin
      if (scl && sda_oe != prev_oe) r8_viol++;
      if (reg_we && (prev_we || reg_re)) r9_viol++;
      prev_oe = sda_oe; prev_we = reg_we;
   end

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
   endtask

   task automatic w(input int n); repeat (n) @(negedge clk); endtask

   task automatic m_start;   sda_m = 1'b1; scl = 1'b1; w(HALF); sda_m = 1'b0; w(HALF); scl = 1'b0; endtask
   task automatic m_rstart;  w(HALF/2); sda_m = 1'b1; w(HALF/2); scl = 1'b1; w(HALF); sda_m = 1'b0; w(HALF); scl = 1'b0; endtask
   task automatic m_stop;    w(HALF/2); sda_m = 1'b0; w(HALF/2); scl = 1'b1; w(HALF); sda_m = 1'b1; w(HALF); endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         w(HALF/2); sda_m = b[i]; w(HALF/2); scl = 1'b1; w(HALF); scl = 1'b0;
      end
      w(HALF/2); sda_m = 1'b1; w(HALF/2); scl = 1'b1; w(HALF/2); ack = ~sda_bus; w(HALF/2); scl = 1'b0;
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         w(HALF/2); sda_m = 1'b1; w(HALF/2); scl = 1'b1; w(HALF/2); b[i] = sda_bus; w(HALF/2); scl = 1'b0;
      end
      w(HALF/2); sda_m = ~give_ack; w(HALF/2); scl = 1'b1; w(HALF); scl = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, output logic [4:0] acks);
      m_start;
      wbyte({DEV, 1'b0}, acks[4]); wbyte(a[15:8], acks[3]); wbyte(a[7:0], acks[2]);
      wbyte(d[15:8], acks[1]); wbyte(d[7:0], acks[0]);
      m_stop;
   endtask

   task automatic do_read(input logic [15:0] a, input logic ack_hi, output logic [15:0] d, output logic [3:0] acks);
      m_start;
      wbyte({DEV, 1'b0}, acks[3]); wbyte(a[15:8], acks[2]); wbyte(a[7:0], acks[1]);
      m_rstart;
      wbyte({DEV, 1'b1}, acks[0]);
      rbyte(ack_hi, d[15:8]); rbyte(1'b0, d[7:0]);
      m_stop;
   endtask

   initial begin
      logic [4:0] wa; logic [3:0] ra; logic [15:0] a, d, rd; logic k; int n0;
      void'($urandom(32'h0000_2C41));
      w(4); rst_n = 1'b1; w(2);
      chk(!sda_oe && !reg_we && !reg_re, "R1 reset idle", {13'd0, sda_oe, reg_we, reg_re}, 16'd0);

      for (int t = 0; t < 4; t++) begin
         a = 16'($urandom); d = 16'($urandom); n0 = we_cnt;
         do_write(a, d, wa);
         chk(wa == 5'b11111, "R3/R4 write acks", {11'd0, wa}, 16'h001F);
         chk(we_cnt == n0 + 1, "R4 one write strobe", 16'(we_cnt - n0), 16'd1);
         chk(we_addr == a && we_data == d, "R4 write addr", we_addr, a);
         chk(we_data == d, "R4 write data", we_data, d);
      end

      for (int t = 0; t < 4; t++) begin
         a = (t == 0) ? 16'hFFFF : 16'($urandom); n0 = re_cnt;
         do_read(a, 1'b1, rd, ra);
         chk(ra == 4'hF, "R6 read acks", {12'd0, ra}, 16'h000F);
         chk(re_cnt == n0 + 1, "R6 one read strobe", 16'(re_cnt - n0), 16'd1);
         chk(rd == model(a), "R6 read data", rd, model(a));
      end

      n0 = we_cnt;
      m_start; wbyte({DEV ^ 7'h01, 1'b0}, k);
      chk(!k, "R3 mismatch nack", {15'd0, k}, 16'd0);
      wbyte(8'h00, k);
      chk(!k, "R3 ignored until start", {15'd0, k}, 16'd0);
      m_stop;
      chk(we_cnt == n0, "R3 no write on mismatch", 16'(we_cnt - n0), 16'd0);

      n0 = we_cnt;
      m_start; wbyte({DEV, 1'b0}, k); wbyte(8'h12, k); m_stop;
      m_start; wbyte({DEV, 1'b0}, k); wbyte(8'h12, k); wbyte(8'h34, k); wbyte(8'h56, k); m_stop;
      chk(we_cnt == n0, "R5 short transfers no write", 16'(we_cnt - n0), 16'd0);

      n0 = we_cnt;
      m_start; wbyte({DEV, 1'b0}, k); wbyte(8'hEE, k);
      m_rstart; wbyte({DEV, 1'b0}, wa[4]); wbyte(8'hA1, wa[3]); wbyte(8'hB2, wa[2]);
      wbyte(8'hC3, wa[1]); wbyte(8'hD4, wa[0]);
      chk(wa == 5'b11111, "R2 acks after restart", {11'd0, wa}, 16'h001F);
      wbyte(8'h77, k);
      chk(!k, "R4 extra byte nack", {15'd0, k}, 16'd0);
      m_stop;
      chk(we_cnt == n0 + 1 && we_addr == 16'hA1B2, "R2 restart addr", we_addr, 16'hA1B2);
      chk(we_data == 16'hC3D4, "R2 restart data", we_data, 16'hC3D4);

      a = 16'h0F0F;
      do_read(a, 1'b0, rd, ra);
      chk(rd[15:8] == model(a) >> 8, "R7 high byte", {8'd0, rd[15:8]}, model(a) >> 8);
      chk(rd[7:0] == 8'hFF, "R7 released after nack", {8'd0, rd[7:0]}, 16'h00FF);

      chk(r8_viol == 0, "R8 oe stable while scl high", 16'(r8_viol), 16'd0);
      chk(r9_viol == 0, "R9 strobe shape", 16'(r9_viol), 16'd0);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1; tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule